// File: doc/BRIEF.md
# Two-Wire Control Register Slave with Indexed and Sequential Access

This block is a slave on a two-wire serial bus (SMBus/I2C electrical protocol, 7-bit addressing). It holds a bank of eight 8-bit control registers and drives them in parallel onto a flat bus. A host can write or read a single register chosen by an offset. It can also stream through the bank in order from register 0 upward.

The first byte after the device address is a command byte. Its top bit chooses the access style: when set, the lower seven bits are the register offset for a one-register access. When clear, the access is sequential from register 0. In a sequential write, the first data byte is a length byte. It is acknowledged and then dropped, and the following bytes fill registers 0, 1, 2 and so on. In a sequential read, the host sends a repeated START and the read address. The slave first returns the bank size, then the register contents in ascending order.

SCL and SDA are brought into the system clock domain through synchronizers. START and STOP are recognised as SDA edges while SCL is high. All SDA changes made by the slave happen only after SCL has gone low.

The controller has these states:
- `ST_IDLE`: waiting for a START.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging a matching address.
- `ST_CMD`: shifting in the command byte.
- `ST_CMD_ACK`: acknowledging the command.
- `ST_WDATA`: shifting in a write byte.
- `ST_WDATA_ACK`: acknowledging the write byte.
- `ST_RDATA`: shifting out a read byte.
- `ST_RDATA_ACK`: the host's acknowledge slot.
- `ST_IGNORE`: not addressed, or the host has sent NACK; waits for START or STOP.

The transitions are:
- A STOP in any state leads to `ST_IDLE`.
- A START in any state leads to `ST_ADDR`.
- All other transitions happen on an SCL falling edge:
  - `ST_ADDR` goes to `ST_ADDR_ACK` after 8 bits if the address matches, and to `ST_IGNORE` otherwise.
  - `ST_ADDR_ACK` goes to `ST_CMD` for a write address and to `ST_RDATA` for a read address.
  - `ST_CMD` goes to `ST_CMD_ACK` after 8 bits, and `ST_CMD_ACK` goes to `ST_WDATA`.
  - `ST_WDATA` goes to `ST_WDATA_ACK` after 8 bits, and `ST_WDATA_ACK` goes back to `ST_WDATA`.
  - `ST_RDATA` goes to `ST_RDATA_ACK` after 8 bits.
  - `ST_RDATA_ACK` goes to `ST_RDATA` if the host acknowledged, and to `ST_IGNORE` if it did not.

Top module: `smb_regbank_slave`

## Requirements
- R1: Reset loads the following values, with register k on `reg_bus[8k+7:8k]`: register 0 = 8'hFF, register 1 = 8'hFE, register 2 = 8'hFF, and registers 3 to 7 = 8'h00. `sda_drive` is 0 during and after reset.
- R2: The slave acknowledges only 7-bit address 7'h69 (8'hD2 for a write, 8'hD3 for a read). After any other address it gives no acknowledge for the rest of that transfer and changes no register.
- R3: A command byte with bit 7 = 1 selects a one-register access at offset bits 6:0. The next written byte is stored in that register. Registers change only through such writes.
- R4: After a one-register command, a repeated START and the read address return the register at the offset, MSB first.
- R5: A command byte with bit 7 = 0 starts a sequential write. The first data byte is a length byte that is acknowledged but not stored. The following bytes go to register 0, then 1, and so on upward.
- R6: After a sequential command, a read returns the byte 8'h08 (the register count) first, then registers 0 upward. Each host ACK gives the next byte. A host NACK ends the read, and the slave then leaves SDA released.
- R7: Writes to offsets of 8 or above are acknowledged and discarded. Reads from offsets of 8 or above return 8'h00.
- R8: The slave pulls SDA low during the ninth clock of every matching address byte, command byte and write data byte.
- R9: A START or STOP at any point aborts the transfer. Registers already written keep their new value. A byte interrupted before its eighth bit writes nothing.
- R10: `sda_drive` changes only while SCL is low, so the slave never creates a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| sda_drive | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_bus | output | 64 | All registers, register k on bits 8k+7:8k |

## Verification
The assertions assume a well-behaved host:
- SCL stays high or low for several system clocks at a time.
- The host changes SDA only while SCL is low, except to form START and STOP.
- The host never issues START or STOP while the slave is driving an acknowledge or a read bit.

Under these conditions the rule that `sda_drive` holds steady while SCL is high is meaningful. The bench host keeps each SCL half period at ten system clocks. It sets SDA a full half period before each rising edge. It issues aborts only while the host itself owns SDA, that is, in the middle of a write byte.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } smb_state_t;

    // Power-up value of each control register
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'hFE;
            2:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file
    import smbreg_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [7:0]      rd_data,
    output logic [NREG*8-1:0] reg_bus
);

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= reg_default(k);
            end else if (wr_en && wr_addr == AW'(k)) begin
                q <= wr_data;
            end
        end
        assign reg_bus[k*8 +: 8] = q;
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == AW'(i)) rd_data = reg_bus[i*8 +: 8];
        end
    end

    // The controller must drop writes that fall outside the bank
    assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < NREG));

    // Without a write strobe the bank holds its contents
    assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_bus));

endmodule

// File: rtl/smb_regbank_slave.sv
module smb_regbank_slave
    import smbreg_pkg::*;
#(
    parameter int         NREG     = 8,
    parameter int         SYNC_LEN = 2,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive,
    output logic [NREG*8-1:0] reg_bus
);

    localparam int AW = 7;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    smb_state_t    state, state_nx;
    logic [3:0]    bit_cnt;
    logic [7:0]    shreg;
    logic [7:0]    tx;
    logic          rw;
    logic          cnt_pend;
    logic          mst_nack;
    logic [AW-1:0] ptr;
    logic [7:0]    rd_data;
    logic          wr_en;
    logic          byte_done;
    logic          load_tx;

    smb_line_sync #(.STAGES(SYNC_LEN)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_reg_file #(.NREG(NREG), .AW(AW)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (shreg),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .reg_bus (reg_bus)
    );

    assign byte_done = (bit_cnt == 4'd8);
    assign load_tx   = scl_fall && ((state == ST_ADDR_ACK && rw) ||
                                    (state == ST_RDATA_ACK && !mst_nack));

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else if (scl_fall) begin
            unique case (state)
                ST_ADDR:      if (byte_done) state_nx = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  state_nx = rw ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_done) state_nx = ST_CMD_ACK;
                ST_CMD_ACK:   state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: state_nx = ST_WDATA;
                ST_RDATA:     if (byte_done) state_nx = ST_RDATA_ACK;
                ST_RDATA_ACK: state_nx = mst_nack ? ST_IGNORE : ST_RDATA;
                ST_IDLE, ST_IGNORE: state_nx = state;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            tx       <= 8'hFF;
            rw       <= 1'b0;
            cnt_pend <= 1'b0;
            mst_nack <= 1'b1;
            ptr      <= '0;
        end else begin
            state <= state_nx;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else begin
                if (scl_rise && (state == ST_ADDR || state == ST_CMD || state == ST_WDATA)) begin
                    shreg   <= {shreg[6:0], sda_s};
                    bit_cnt <= bit_cnt + 4'd1;
                end
                if (scl_rise && state == ST_RDATA)     bit_cnt  <= bit_cnt + 4'd1;
                if (scl_rise && state == ST_RDATA_ACK) mst_nack <= sda_s;
                if (load_tx) begin
                    tx <= cnt_pend ? 8'(NREG) : rd_data;
                    if (cnt_pend)        cnt_pend <= 1'b0;
                    else if (ptr != '1)  ptr      <= ptr + 1'b1;
                end
                if (scl_fall) begin
                    unique case (state)
                        ST_ADDR:  if (byte_done) rw <= shreg[0];
                        ST_CMD: if (byte_done) begin
                            ptr      <= shreg[7] ? shreg[6:0] : '0;
                            cnt_pend <= ~shreg[7];
                        end
                        ST_WDATA: if (byte_done) begin
                            if (cnt_pend)       cnt_pend <= 1'b0;
                            else if (ptr != '1) ptr      <= ptr + 1'b1;
                        end
                        ST_RDATA: if (!byte_done) tx <= {tx[6:0], 1'b1};
                        ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK, ST_RDATA_ACK: bit_cnt <= '0;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Outputs
    always_comb begin
        sda_drive = (state == ST_ADDR_ACK) || (state == ST_CMD_ACK) ||
                    (state == ST_WDATA_ACK) || (state == ST_RDATA && !tx[7]);
        wr_en     = (state == ST_WDATA) && scl_fall && byte_done && !cnt_pend &&
                    (int'(ptr) < NREG);
    end

    assert_sda_quiet_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_drive));

    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive);

    assert_bit_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

    assert_foreign_addr_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && byte_done && shreg[7:1] != DEV_ADDR) |=> !sda_drive);

endmodule

// File: tb/test_smb_regbank_slave.sv
module test_smb_regbank_slave;

    localparam int HALF = 10;
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive;
    logic [NREG*8-1:0] reg_bus;
    logic sda_line;

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;
    logic [7:0] model [NREG];

    // {offset, write data, expected read}
    localparam logic [23:0] VEC [8] = '{
        {8'h00, 8'hA5, 8'hA5},
        {8'h01, 8'h3C, 8'h3C},
        {8'h07, 8'h81, 8'h81},
        {8'h04, 8'h00, 8'h00},
        {8'h02, 8'hF0, 8'hF0},
        {8'h09, 8'h77, 8'h00},
        {8'h7F, 8'h12, 8'h00},
        {8'h03, 8'h5A, 8'h5A}
    };

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_drive;

    smb_regbank_slave i_smb_regbank_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_drive (sda_drive),
        .reg_bus   (reg_bus)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] model_bus();
        logic [63:0] b;
        for (int k = 0; k < NREG; k++) b[k*8 +: 8] = model[k];
        return b;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NREG; k++) model[k] = 8'h00;
        model[0] = 8'hFF; model[1] = 8'hFE; model[2] = 8'hFF;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b0; wt(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        sda_m = 1'b1; wt(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; wt(HALF);
            scl_m = 1'b1; wt(HALF);
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wt(HALF);
        scl_m = 1'b1; wt(HALF/2);
        ack = ~sda_line;
        wt(HALF/2);
        scl_m = 1'b0; wt(HALF);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(HALF);
            scl_m = 1'b1; wt(HALF/2);
            d[i] = sda_line;
            wt(HALF/2);
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        scl_m = 1'b0; wt(HALF);
        sda_m = 1'b1;
    endtask

    task automatic byte_write(input logic [7:0] off, input logic [7:0] d);
        logic a;
        bus_start();
        send_byte(8'hD2, a);        chk("R8 addr ack", a, 1);
        send_byte(8'h80 | off, a);  chk("R8 cmd ack", a, 1);
        send_byte(d, a);            chk("R8 data ack", a, 1);
        bus_stop();
    endtask

    task automatic byte_read(input logic [7:0] off, output logic [7:0] d);
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h80 | off, a);
        bus_start();
        send_byte(8'hD3, a);        chk("R2 read addr ack", a, 1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic a;
        logic [7:0] d;
        logic [63:0] snap;
        model_reset();
        wt(5);
        chk("R1 reset value during reset", reg_bus, model_bus());
        rst_n = 1'b1;
        wt(5);
        chk("R1 reset value", reg_bus, model_bus());
        chk("R1 sda released", sda_drive, 0);

        // Table walk: one-register write then read back (R3, R4, R7)
        for (int v = 0; v < 8; v++) begin
            logic [7:0] off, wd, ex;
            {off, wd, ex} = VEC[v];
            snap = reg_bus;
            byte_write(off, wd);
            if (off < NREG) model[off] = wd;
            chk((off < NREG) ? "R3 byte write" : "R7 out-of-range write dropped", reg_bus, model_bus());
            byte_read(off, d);
            chk((off < NREG) ? "R4 byte read" : "R7 out-of-range read zero", d, ex);
        end

        // R2: foreign address gets no ack and writes nothing
        snap = reg_bus;
        bus_start();
        send_byte(8'hD4, a);   chk("R2 foreign addr nack", a, 0);
        send_byte(8'h81, a);   chk("R2 no ack after foreign addr", a, 0);
        send_byte(8'h00, a);
        bus_stop();
        chk("R2 foreign write no effect", reg_bus, snap);
        chk("R10 sda released after stop", sda_drive, 0);

        // R5: sequential write, length byte then data from register 0
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);   chk("R8 block cmd ack", a, 1);
        send_byte(8'h03, a);   chk("R5 length byte ack", a, 1);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop();
        model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
        chk("R5 block write", reg_bus, model_bus());

        // R6: sequential read, count first then registers upward
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b1, d);    chk("R6 count byte", d, 8'h08);
        for (int k = 0; k < NREG; k++) begin
            recv_byte(k != NREG - 1, d);
            chk("R6 block read data", d, model[k]);
        end
        chk("R6 sda released after nack", sda_drive, 0);
        bus_stop();

        // R9: STOP inside a byte keeps completed bytes only
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h02, a);
        send_byte(8'h44, a);
        send_byte(8'h55, a);
        send_bits(8'h66, 4);
        bus_stop();
        model[0] = 8'h44; model[1] = 8'h55;
        chk("R9 abort by stop", reg_bus, model_bus());

        // R9: START inside a byte aborts, new transfer proceeds
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h85, a);
        send_bits(8'h99, 3);
        chk("R9 partial byte not written", reg_bus, model_bus());
        bus_start();
        send_byte(8'hD2, a);   chk("R9 address after abort acked", a, 1);
        send_byte(8'h85, a);
        send_byte(8'h42, a);
        bus_stop();
        model[5] = 8'h42;
        chk("R9 transfer after abort", reg_bus, model_bus());

        // R1: reset in mid-run restores defaults
        wt(3);
        rst_n = 1'b0;
        wt(3);
        model_reset();
        rst_n = 1'b1;
        wt(3);
        chk("R1 defaults after second reset", reg_bus, model_bus());
        byte_read(8'h01, d);
        chk("R1 default read back", d, 8'hFE);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule